// File: doc/BRIEF.md
# External Interrupt Request Controller

This block turns one active-low external interrupt pin into a held interrupt request for a processor's priority logic. The raw pin is resynchronised into the clock domain. A high-to-low transition of the synchronised level always sets a request latch. A control bit can make the pin level-sensitive as well: the request then survives for as long as the pin stays low, and it is released only after the pin has gone high again and the request has been acknowledged, in either order.

An acknowledge comes from a software write of 1 to the acknowledge bit of the status/control byte, or from a vector-fetch strobe driven by the processor. A mask bit blocks the request from reaching the output and leaves the latch as it is. The synchronised pin level is also brought out, so that branch-on-pin instructions can test it.

Top module: `ext_irq_ctrl`

## Requirements
- R1: During reset and after it, `regRdata` reads 0x00 and `irqReq` is 0. The mask bit and the level-mode bit reset to 0. The synchronizer resets to 0, so a pin that is already low when reset ends raises no request.
- R2: A high-to-low transition on `pinN` sets the flag at read bit 3 and `irqReq` at the third rising clock edge after the transition. A low-to-high transition sets nothing.
- R3: In edge-only mode (read bit 0 = 0), the flag stays set whatever the pin does. A register write with bit 2 = 1 clears it at that write's edge. A write with bit 2 = 0 leaves it set.
- R4: A one-cycle `vecFetch` pulse clears the flag in the same way as a software acknowledge.
- R5: In level mode (bit 0 = 1), an acknowledge while the synchronised pin is low does not clear the flag. Once the pin returns high, the flag clears at the third rising edge after the pin's rising transition.
- R6: In level mode, if the pin returns high before any acknowledge, the flag stays set until an acknowledge arrives and then clears at that acknowledge's edge.
- R7: While the mask bit (read/write bit 1) is 1, `irqReq` is 0 and the flag keeps its value. Clearing the mask brings `irqReq` back if the flag is set.
- R8: Read bits 7..4 and bit 2 are always 0. Bits 1 and 0 read back the last written mask and mode. Writes to bit 3 have no effect.
- R9: If a falling edge is detected in the same cycle as an acknowledge, the set wins and the flag ends up set.
- R10: `pinLevel` follows `pinN`, two rising edges later.
- R11: Reset in level mode with the pin held low clears the flag and the mode bit, and no request reappears after reset while the pin stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinN | input | 1 | Raw active-low interrupt pin |
| vecFetch | input | 1 | One-cycle strobe: the processor is fetching this interrupt's vector |
| regWe | input | 1 | Write strobe for the status/control byte |
| regWdata | input | 8 | Write data (bit 2 acknowledge, bit 1 mask, bit 0 level mode) |
| regRdata | output | 8 | Read data (bit 3 flag, bit 1 mask, bit 0 mode, other bits 0) |
| irqReq | output | 1 | Interrupt request to the priority logic |
| pinLevel | output | 1 | Synchronised pin level |

## Verification
The bench places an acknowledge on the very cycle that a falling edge is detected. A design that gave the clear priority would lose that interrupt.

In level mode it runs both orders of acknowledge and pin release. A design that cleared on the acknowledge alone would drop a request while the pin is still low. A design that cleared on the pin rising alone would drop a request that was never serviced.

It releases reset with the pin held low. A synchronizer that reset to the idle-high level would invent an edge at that point and raise a spurious request.

It also checks that masking hides the request while the flag holds, and that writes of 0 to the acknowledge bit and writes to the flag bit do nothing. This catches decoders that key on the wrong bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_MODE = 0;
  localparam int BIT_MASK = 1;
  localparam int BIT_ACK  = 2;
  localparam int BIT_FLAG = 3;

  typedef struct packed {
    logic clearReq;   // acknowledge pulse, software or vector fetch
    logic levelMode;  // 1: edge plus low-level sensitivity
    logic maskOn;     // 1: request withheld from output
  } irqStrobes_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  input  logic             vecFetch,
  input  logic             flag,
  output irqStrobes_t      strobes,
  output logic [REG_W-1:0] regRdata
);
  logic modeQ;
  logic maskQ;
  logic swAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= 1'b0;
      maskQ <= 1'b0;
    end else if (regWe) begin
      modeQ <= regWdata[BIT_MODE];
      maskQ <= regWdata[BIT_MASK];
    end
  end

  assign swAck = regWe & regWdata[BIT_ACK];

  always_comb begin
    strobes.clearReq  = swAck | vecFetch;
    strobes.levelMode = modeQ;
    strobes.maskOn    = maskQ;
  end

  always_comb begin
    regRdata           = '0;
    regRdata[BIT_MODE] = modeQ;
    regRdata[BIT_MASK] = maskQ;
    regRdata[BIT_FLAG] = flag;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinN,
  input  irqStrobes_t strobes,
  output logic        flag,
  output logic        irqReq,
  output logic        pinLevel
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          prevLevel;
  logic          fallSeen;
  logic          latchQ;
  logic          ackSeenQ;
  logic          ackNow;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= pinN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[LAST-1:0], pinN};
      end
    end
  endgenerate

  assign pinLevel = syncQ[LAST];
  assign fallSeen = prevLevel & ~pinLevel;
  assign ackNow   = ackSeenQ | strobes.clearReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= 1'b0;
      latchQ    <= 1'b0;
      ackSeenQ  <= 1'b0;
    end else begin
      prevLevel <= pinLevel;
      if (fallSeen) begin
        latchQ   <= 1'b1;
        ackSeenQ <= 1'b0;
      end else if (!strobes.levelMode) begin
        ackSeenQ <= 1'b0;
        if (strobes.clearReq) latchQ <= 1'b0;
      end else if (latchQ) begin
        if (ackNow && pinLevel) begin
          latchQ   <= 1'b0;
          ackSeenQ <= 1'b0;
        end else begin
          ackSeenQ <= ackNow;
        end
      end else begin
        ackSeenQ <= 1'b0;
      end
    end
  end

  assign flag   = latchQ;
  assign irqReq = latchQ & ~strobes.maskOn;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinN,
  input  logic             vecFetch,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  output logic             irqReq,
  output logic             pinLevel
);
  irqStrobes_t strobes;
  logic        flag;

  irq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regWdata (regWdata),
    .vecFetch (vecFetch),
    .flag     (flag),
    .strobes  (strobes),
    .regRdata (regRdata)
  );

  irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinN     (pinN),
    .strobes  (strobes),
    .flag     (flag),
    .irqReq   (irqReq),
    .pinLevel (pinLevel)
  );
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       vecFetch,
  input logic       regWe,
  input logic [7:0] regWdata,
  input logic [7:0] regRdata,
  input logic       irqReq,
  input logic       pinLevel
);
  // R8
  fixed_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[7:4] == 4'b0) && !regRdata[2]);

  // R7
  mask_hides_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[1] |-> !irqReq);

  // R2
  fall_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinLevel) |=> regRdata[3]);

  // R3
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdata[0] && regRdata[3] && !vecFetch && !(regWe && regWdata[2]))
    |=> regRdata[3]);

  // R4
  vec_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecFetch && !regRdata[0] && !$fell(pinLevel)) |=> !regRdata[3]);

  // R5
  level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[0] && regRdata[3] && !pinLevel) |=> regRdata[3]);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .vecFetch (vecFetch),
  .regWe    (regWe),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .irqReq   (irqReq),
  .pinLevel (pinLevel)
);

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinN = 1'b1;
  logic       vecFetch = 1'b0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       irqReq;
  logic       pinLevel;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  ext_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .pinN(pinN), .vecFetch(vecFetch),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .irqReq(irqReq), .pinLevel(pinLevel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = 8'h00;
  endtask

  task automatic vecPulse();
    @(negedge clk);
    vecFetch = 1'b1;
    @(negedge clk);
    vecFetch = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cyc(2);
    rstN = 1'b1;
  endtask

  task automatic pinFall();
    @(negedge clk);
    pinN = 1'b0;
    cyc(3);
  endtask

  task automatic pinRise();
    @(negedge clk);
    pinN = 1'b1;
    cyc(3);
  endtask

  task automatic t_reset();
    check(regRdata == 8'h00 && !irqReq, "R1 in reset", regRdata, 0);
    rstN = 1'b1;
    cyc(3);
    check(regRdata == 8'h00 && !irqReq, "R1 after reset", regRdata, 0);
    check(pinLevel == 1'b1, "R10 idle level", pinLevel, 1);
  endtask

  task automatic t_edgeTiming();
    @(negedge clk);
    pinN = 1'b0;
    cyc(1);
    check(pinLevel == 1'b1, "R10 one edge", pinLevel, 1);
    cyc(1);
    check(pinLevel == 1'b0, "R10 two edges", pinLevel, 0);
    check(regRdata[3] == 1'b0, "R2 not before third edge", regRdata[3], 0);
    cyc(1);
    check(regRdata[3] && irqReq, "R2 set at third edge", {regRdata[3], irqReq}, 3);
    pinRise();
    check(regRdata[3] == 1'b1, "R3 holds after pin high", regRdata[3], 1);
    regWrite(8'h00);
    check(regRdata[3] == 1'b1, "R3 ack=0 no effect", regRdata[3], 1);
    regWrite(8'h08);
    check(regRdata == 8'h08, "R8 flag bit write ignored", regRdata, 8'h08);
    regWrite(8'h04);
    check(regRdata[3] == 1'b0 && !irqReq, "R3 soft ack clears", regRdata[3], 0);
  endtask

  task automatic t_riseNoSet();
    @(negedge clk); pinN = 1'b0;
    cyc(3);
    regWrite(8'h04);
    pinRise();
    cyc(2);
    check(regRdata[3] == 1'b0, "R2 rising edge sets nothing", regRdata[3], 0);
  endtask

  task automatic t_vecFetch();
    pinFall();
    check(regRdata[3] == 1'b1, "R4 setup", regRdata[3], 1);
    vecPulse();
    check(regRdata[3] == 1'b0 && !irqReq, "R4 vector fetch clears", regRdata[3], 0);
    pinRise();
  endtask

  task automatic t_mask();
    regWrite(8'h02);
    check(regRdata == 8'h02, "R8 mask readback", regRdata, 8'h02);
    pinFall();
    check(regRdata[3] && !irqReq, "R7 masked, flag held", {regRdata[3], irqReq}, 2);
    regWrite(8'h00);
    check(irqReq == 1'b1, "R7 unmask restores", irqReq, 1);
    regWrite(8'h04);
    pinRise();
  endtask

  task automatic t_collide();
    @(negedge clk);
    pinN = 1'b0;
    cyc(2);
    regWe = 1'b1; regWdata = 8'h04;
    @(negedge clk);
    regWe = 1'b0; regWdata = 8'h00;
    check(regRdata[3] == 1'b1, "R9 set wins over ack", regRdata[3], 1);
    regWrite(8'h04);
    pinRise();
  endtask

  task automatic t_levelAckFirst();
    regWrite(8'h01);
    check(regRdata == 8'h01, "R8 mode readback", regRdata, 8'h01);
    pinFall();
    regWrite(8'h05);
    check(regRdata[3] == 1'b1, "R5 ack while low holds", regRdata[3], 1);
    vecPulse();
    cyc(4);
    check(regRdata[3] && irqReq, "R5 still pending while low", regRdata[3], 1);
    @(negedge clk);
    pinN = 1'b1;
    cyc(2);
    check(regRdata[3] == 1'b1, "R5 not before third edge", regRdata[3], 1);
    cyc(1);
    check(regRdata[3] == 1'b0, "R5 clears after pin high", regRdata[3], 0);
  endtask

  task automatic t_levelHighFirst();
    pinFall();
    pinRise();
    cyc(3);
    check(regRdata[3] == 1'b1, "R6 held without ack", regRdata[3], 1);
    regWrite(8'h05);
    check(regRdata[3] == 1'b0, "R6 ack clears", regRdata[3], 0);
  endtask

  task automatic t_resetLow();
    pinFall();
    check(regRdata == 8'h09, "R11 setup", regRdata, 8'h09);
    doReset();
    cyc(5);
    check(regRdata == 8'h00 && !irqReq, "R11 reset clears with pin low", regRdata, 0);
    check(pinLevel == 1'b0, "R10 low level", pinLevel, 0);
    pinRise();
  endtask

  initial begin
    fork
      begin
        cyc(3);
        t_reset();
        t_edgeTiming();
        t_riseNoSet();
        t_vecFetch();
        t_mask();
        t_collide();
        t_levelAckFirst();
        t_levelHighFirst();
        t_resetLow();
      end
      begin
        cyc(5000);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule